// File: doc/BRIEF.md
# Prescaled reload timer with polarity output

This block is a 16-bit up-counting timer. A power-of-two prescaler sits in front of it, and a single output level toggles each time the counter reloads. Software supplies five controls: an enable bit, a 4-bit mode value (one high bit and three low bits, held as separate inputs), a 3-bit prescale code, a 16-bit reload value and a polarity bit. Only the continuous reload mode, code 0001, makes the counter run.

While the timer is disabled, the output follows the polarity bit and the prescaler is held at zero. Once the timer runs, the output changes only at a reload. At each reload a one-clock pulse is also raised, which can serve as an interrupt request. The current count is visible at all times.

Top module: `prescaled_reload_timer`

## Requirements
- R1: A synchronous active-low reset sets the count to 0x0001, the output to 0 and the reload pulse to 0.
- R2: The timer runs when enable is 1 and {mode_hi, mode_lo} equals 4'b0001. While it runs, the prescaler produces one tick every 2^prescale clocks (code 0 gives a ratio of 1, code 7 gives 128). The first tick comes 2^prescale clocks after enable.
- R3: The count starts at 0x0001 and increments by one on each tick. On a tick where the count equals the reload value, the count returns to 0x0001. A reload value R therefore gives a reload every R·2^prescale clocks.
- R4: At each reload the output inverts, and the reload pulse is 1 for exactly that one cycle.
- R5: While enable is 0, the output takes the polarity value one clock later and the count holds its value.
- R6: A change of polarity while the timer runs leaves the output unchanged until the timer is disabled.
- R7: The prescaler is cleared while enable is 0, so a restart waits a full prescale period before the first tick.
- R8: A reload value of 0x0000 acts as 0x10000. The counter passes through 0x0000 and reloads 65536 ticks after it starts.
- R9: A change of the prescale code while the timer runs takes effect only after the next tick. The current period is never cut short.
- R10: With enable at 1 and any mode code other than 0001, the count, the output and the pulse all hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Timer enable |
| mode_hi | input | 1 | Most significant bit of the mode code |
| mode_lo | input | 3 | Low three bits of the mode code |
| prescale | input | 3 | Prescale code, ratio 2^code |
| reload | input | 16 | Reload value (0 means 65536) |
| polarity | input | 1 | Idle output level |
| tmr_out | output | 1 | Timer output level |
| reload_pulse | output | 1 | One-cycle pulse at each reload |
| count | output | 16 | Current count |

## Verification
Two cases are the hardest to reach from the ports. One is a prescale change that arrives partway through a long period. The other is a disable that lands between ticks. The bench reaches both by setting inputs on chosen falling edges. It switches from a ratio of 8 to a ratio of 1 three clocks in, and it drops enable for one cycle two clocks into a period of 4. In each case it counts the exact clock at which the count next moves. The full-range reload is driven to its 65536th tick at a ratio of 1.

// File: rtl/prescaled_reload_timer.sv
module prescaled_reload_timer #(
  parameter int CW = 16,
  parameter int PW = 3,
  parameter logic [3:0] RUN_MODE = 4'b0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          mode_hi,
  input  logic [2:0]    mode_lo,
  input  logic [PW-1:0] prescale,
  input  logic [CW-1:0] reload,
  input  logic          polarity,
  output logic          tmr_out,
  output logic          reload_pulse,
  output logic [CW-1:0] count
);
  localparam int DIVW = (1 << PW) - 1;

  logic [DIVW-1:0] presc;
  logic [PW-1:0]   ps_q;
  logic [DIVW:0]   span;
  logic [DIVW-1:0] limit;
  logic            run, tick, at_top;

  assign run    = enable && ({mode_hi, mode_lo} == RUN_MODE);
  assign span   = {{DIVW{1'b0}}, 1'b1} << ps_q;
  assign limit  = DIVW'(span - 1'b1);
  assign tick   = run && (presc == limit);
  assign at_top = (count == reload);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count        <= CW'(1);
      presc        <= '0;
      ps_q         <= '0;
      tmr_out      <= 1'b0;
      reload_pulse <= 1'b0;
    end else begin
      reload_pulse <= 1'b0;
      if (!run) begin
        presc <= '0;
        ps_q  <= prescale;
        if (!enable) tmr_out <= polarity;
      end else if (tick) begin
        presc <= '0;
        ps_q  <= prescale;
        if (at_top) begin
          count        <= CW'(1);
          tmr_out      <= ~tmr_out;
          reload_pulse <= 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end else begin
        presc <= presc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/prescaled_reload_timer_chk.sv
module prescaled_reload_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic        mode_hi,
  input logic [2:0]  mode_lo,
  input logic [2:0]  prescale,
  input logic [15:0] reload,
  input logic        polarity,
  input logic        tmr_out,
  input logic        reload_pulse,
  input logic [15:0] count
);
  assert_reload_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reload_pulse |-> count == 16'h0001);

  assert_pulse_toggles_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && reload_pulse) |-> tmr_out != $past(tmr_out));

  assert_idle_polarity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(enable)) |-> tmr_out == $past(polarity));

  assert_run_hold_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(enable) && !reload_pulse) |-> $stable(tmr_out));

  assert_other_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(enable) && ({$past(mode_hi), $past(mode_lo)} != 4'b0001))
      |-> ($stable(count) && !reload_pulse));
endmodule

bind prescaled_reload_timer prescaled_reload_timer_chk u_chk (.*);

// File: tb/prescaled_reload_timer_bench.sv
module prescaled_reload_timer_bench;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0, enable = 0, mode_hi = 0, polarity = 0;
  logic [2:0] mode_lo = 3'b001, prescale = 0;
  logic [15:0] reload = 16'd3;
  logic tmr_out, reload_pulse;
  logic [15:0] count;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  prescaled_reload_timer u_prescaled_reload_timer (.*);

  localparam logic [19:0] VEC [5] = '{
    {3'd0, 16'd3, 1'b0}, {3'd1, 16'd4, 1'b1}, {3'd2, 16'd2, 1'b0},
    {3'd3, 16'd1, 1'b1}, {3'd7, 16'd2, 1'b0}};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; enable = 0; mode_hi = 0; mode_lo = 3'b001;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wait_pulse(output int n, input int lim);
    n = 0;
    do begin @(negedge clk); n++; end while (!reload_pulse && n < lim);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    do_reset();
    @(negedge clk);
    check("R1 count", count, 1);
    check("R1 out", tmr_out, 0);
    check("R1 pulse", reload_pulse, 0);

    for (int i = 0; i < 5; i++) begin
      int p, r, per;
      do_reset();
      prescale = VEC[i][19:17]; reload = VEC[i][16:1]; polarity = VEC[i][0];
      p = prescale; r = reload; per = r << p;
      @(negedge clk);
      check("R5 idle out", tmr_out, polarity);
      enable = 1;
      wait_pulse(n, 5000);
      check("R2 R3 first reload", n, per);
      check("R4 out toggled", tmr_out, !polarity);
      check("R3 count reloaded", count, 1);
      if (per > 1) begin
        @(negedge clk);
        check("R4 pulse one cycle", reload_pulse, 0);
        wait_pulse(n, 5000);
        check("R2 R3 second interval", n + 1, per);
        check("R4 out back", tmr_out, polarity);
      end
    end

    do_reset();
    prescale = 0; reload = 16'd10; polarity = 0;
    @(negedge clk);
    enable = 1;
    repeat (3) @(negedge clk);
    check("R3 count increments", count, 4);
    polarity = 1;
    repeat (3) @(negedge clk);
    check("R6 out unchanged", tmr_out, 0);
    enable = 0;
    @(negedge clk);
    check("R5 out follows polarity", tmr_out, 1);
    repeat (3) @(negedge clk);
    check("R5 count held", count, 7);

    do_reset();
    prescale = 0; reload = 16'd3; polarity = 0; mode_lo = 3'b000;
    enable = 1;
    repeat (6) @(negedge clk);
    check("R10 mode 0000 count", count, 1);
    check("R10 mode 0000 out", tmr_out, 0);
    mode_hi = 1; mode_lo = 3'b001;
    repeat (6) @(negedge clk);
    check("R10 mode 1001 count", count, 1);

    do_reset();
    prescale = 3'd2; reload = 16'd5;
    @(negedge clk);
    enable = 1;
    repeat (2) @(negedge clk);
    enable = 0;
    @(negedge clk);
    enable = 1;
    repeat (3) @(negedge clk);
    check("R7 no early tick", count, 1);
    @(negedge clk);
    check("R7 full period tick", count, 2);

    do_reset();
    prescale = 3'd3; reload = 16'd2;
    @(negedge clk);
    enable = 1;
    repeat (3) @(negedge clk);
    prescale = 3'd0;
    repeat (4) @(negedge clk);
    check("R9 period not cut", count, 1);
    @(negedge clk);
    check("R9 old period tick", count, 2);
    @(negedge clk);
    check("R9 new ratio reload", reload_pulse, 1);

    do_reset();
    prescale = 0; reload = 16'd0;
    @(negedge clk);
    enable = 1;
    repeat (65535) @(negedge clk);
    check("R8 passes zero", count, 0);
    check("R8 no early pulse", reload_pulse, 0);
    @(negedge clk);
    check("R8 reload at 65536", reload_pulse, 1);
    check("R8 count reloaded", count, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule